// File: doc/BRIEF.md
# GPIO Port with Change Interrupt

This block is an 8-bit general-purpose I/O port for a small microcontroller bus. It holds an output data latch, a direction latch with one bit per pin, and a single active-low bit that enables the weak pull-ups on all pins. The pad side receives a drive value, a per-pin output enable and a per-pin pull-up enable. It returns the pin levels, which must already be synchronized.

The upper four pins can raise a change interrupt. Each upper pin that is configured as an input is compared against a snapshot. The snapshot is taken on every port read and on every port write. It is not taken every clock. While any compared pin differs from its snapshot, a wake request is high. The same condition sets a sticky flag on each cycle. Software must read or write the port, which ends the mismatch, before a flag clear will stick.

The bus side uses separate strobes for port write, port read, direction write, direction read, pull-up control write and flag clear.

Top module: `gpio_chg_port`

## Requirements
- R1: A `wr_dir` strobe loads `wr_data` into the direction latch. A direction bit of 1 makes that pin an input and drives its `pad_oe` bit low. A direction bit of 0 makes it an output and drives `pad_oe` high.
- R2: A `wr_port` strobe loads `wr_data` into the output latch. `pad_out` always presents the latch contents.
- R3: A `wr_pucfg` strobe loads `wr_data[0]` into the active-low pull-up control bit. `pad_pu[i]` is 1 only when direction bit i is 1 and the control bit is 0. It is never 1 on an output pin.
- R4: After reset, the direction latch is all ones and the pull-up control bit is 1, so no pull-ups are on. The output latch is zero and `irq_flag` is 0.
- R5: While `rd_port` is high, `rd_data` equals `pin_in` on all eight bits, whatever their direction. While `rd_dir` is high, `rd_data` equals the direction latch. With neither strobe high, `rd_data` is zero.
- R6: A mismatch exists when any of bits 7..4 is an input and its `pin_in` level differs from the snapshot. A mismatch sets `irq_flag` at the next clock edge. Bits 3..0 and output-configured upper pins never cause a mismatch.
- R7: On any cycle with `rd_port` or `wr_port` high, the snapshot captures `pin_in[7:4]` at that clock edge. This ends the mismatch.
- R8: `irq_flag` stays set until `flag_clr` is applied. `flag_clr` clears the flag at the next edge, except when a mismatch exists in the same cycle; in that case the set wins.
- R9: `wake_req` is high, with no clock delay, exactly while a mismatch exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_data | input | 8 | Write data from the bus |
| wr_port | input | 1 | Write strobe for the output latch; also refreshes the snapshot |
| rd_port | input | 1 | Read strobe for the pin levels; also refreshes the snapshot |
| wr_dir | input | 1 | Write strobe for the direction latch |
| rd_dir | input | 1 | Read strobe for the direction latch |
| wr_pucfg | input | 1 | Write strobe for the pull-up control bit (`wr_data[0]`) |
| flag_clr | input | 1 | Clear strobe for the change flag |
| pin_in | input | 8 | Synchronized pin levels |
| rd_data | output | 8 | Read data to the bus |
| pad_out | output | 8 | Drive value to the pads |
| pad_oe | output | 8 | Per-pin output enable |
| pad_pu | output | 8 | Per-pin weak pull-up enable |
| irq_flag | output | 1 | Sticky port-change flag |
| wake_req | output | 1 | Live mismatch, usable as a wake source |

## Verification
Some properties are checked on every cycle. A pull-up is never enabled on a driven pin. A live mismatch is always followed by a set flag. A flag clear without a mismatch always takes effect. Each port access reloads the snapshot from the pins, and the flag never rises without a prior wake request.

Other behaviour is shown only by the bench scenarios. These include the reset values and the read-back mux contents. They also include the exclusion of the lower pins and of output-configured upper pins from the compare. Finally, they show that an access ends the mismatch while leaving the sticky flag in place, and that the set wins when it collides with a clear.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int PORT_W  = 8;
  localparam int CHG_LO  = 4;
  localparam int CHG_W   = PORT_W - CHG_LO;

  // pull-up active on inputs only, when the global active-low bit is 0
  function automatic logic [PORT_W-1:0] pullup_mask(input logic [PORT_W-1:0] dir,
                                                    input logic pu_n);
    pullup_mask = dir & {PORT_W{~pu_n}};
  endfunction

  // per-bit disagreement between the upper pins and the snapshot, inputs only
  function automatic logic [CHG_W-1:0] change_bits(input logic [CHG_W-1:0] pins,
                                                   input logic [CHG_W-1:0] snap,
                                                   input logic [CHG_W-1:0] dir_hi);
    change_bits = (pins ^ snap) & dir_hi;
  endfunction
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] wr_data,
  input  logic              wr_port,
  input  logic              wr_dir,
  input  logic              wr_pucfg,
  output logic [PORT_W-1:0] out_q,
  output logic [PORT_W-1:0] dir_q,
  output logic              pu_n_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '1;
      pu_n_q <= 1'b1;
    end else begin
      if (wr_port)   out_q  <= wr_data;
      if (wr_dir)    dir_q  <= wr_data;
      if (wr_pucfg)  pu_n_q <= wr_data[0];
    end
  end

  assert_dir_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> dir_q == $past(wr_data));
  assert_out_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_port |=> out_q == $past(wr_data));
  assert_out_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_port |=> $stable(out_q));
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] out_q,
  input  logic [PORT_W-1:0] dir_q,
  input  logic              pu_n_q,
  output logic [PORT_W-1:0] pad_out,
  output logic [PORT_W-1:0] pad_oe,
  output logic [PORT_W-1:0] pad_pu
);
  logic [PORT_W-1:0] pu_mask;
  assign pu_mask = pullup_mask(dir_q, pu_n_q);

  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    assign pad_out[i] = out_q[i];
    assign pad_oe[i]  = ~dir_q[i];
    assign pad_pu[i]  = pu_mask[i];
  end

  assert_pu_not_driven_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == '0);
  assert_pu_off_when_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pu_n_q |-> pad_pu == '0);
endmodule

// File: rtl/gpio_chg_det.sv
module gpio_chg_det
  import gpio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] pin_in,
  input  logic [PORT_W-1:0] dir_q,
  input  logic              access,
  input  logic              flag_clr,
  output logic              mismatch,
  output logic              irq_flag
);
  logic [CHG_W-1:0] snap_q;
  logic [CHG_W-1:0] diff_bits;
  logic [CHG_W-1:0] pins_hi;

  assign pins_hi   = pin_in[PORT_W-1:CHG_LO];
  assign diff_bits = change_bits(pins_hi, snap_q, dir_q[PORT_W-1:CHG_LO]);
  assign mismatch  = |diff_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q   <= '0;
      irq_flag <= 1'b0;
    end else begin
      if (access) snap_q <= pins_hi;
      if (mismatch)      irq_flag <= 1'b1;
      else if (flag_clr) irq_flag <= 1'b0;
    end
  end

  assert_snap_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    access |=> snap_q == $past(pins_hi));
  assert_mismatch_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> irq_flag);
  assert_clear_works_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !mismatch) |=> !irq_flag);
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !flag_clr) |=> irq_flag);
endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port
  import gpio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] wr_data,
  input  logic              wr_port,
  input  logic              rd_port,
  input  logic              wr_dir,
  input  logic              rd_dir,
  input  logic              wr_pucfg,
  input  logic              flag_clr,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] rd_data,
  output logic [PORT_W-1:0] pad_out,
  output logic [PORT_W-1:0] pad_oe,
  output logic [PORT_W-1:0] pad_pu,
  output logic              irq_flag,
  output logic              wake_req
);
  logic [PORT_W-1:0] out_q;
  logic [PORT_W-1:0] dir_q;
  logic              pu_n_q;
  logic              port_access;
  logic              mismatch;

  assign port_access = rd_port | wr_port;

  gpio_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_port(wr_port),
    .wr_dir(wr_dir), .wr_pucfg(wr_pucfg),
    .out_q(out_q), .dir_q(dir_q), .pu_n_q(pu_n_q)
  );

  gpio_pad_ctrl u_pads (
    .clk(clk), .rst_n(rst_n), .out_q(out_q), .dir_q(dir_q), .pu_n_q(pu_n_q),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
  );

  gpio_chg_det u_chg (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .dir_q(dir_q),
    .access(port_access), .flag_clr(flag_clr),
    .mismatch(mismatch), .irq_flag(irq_flag)
  );

  assign wake_req = mismatch;

  always_comb begin
    if (rd_dir)       rd_data = dir_q;
    else if (rd_port) rd_data = pin_in;
    else              rd_data = '0;
  end

  assert_flag_needs_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(wake_req));
endmodule

// File: tb/gpio_chg_port_test.sv
module gpio_chg_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_port = 0, rd_port = 0, wr_dir = 0, rd_dir = 0, wr_pucfg = 0, flag_clr = 0;
  logic [7:0] pin_in = '0;
  logic [7:0] rd_data, pad_out, pad_oe, pad_pu;
  logic       irq_flag, wake_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    int         sel;   // 0 rd_data 1 pad_out 2 pad_oe 3 pad_pu 4 irq_flag 5 wake_req
    logic [7:0] exp;
    string      tag;
  } exp_t;
  exp_t sb[$];

  gpio_chg_port uut (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_port(wr_port), .rd_port(rd_port),
    .wr_dir(wr_dir), .rd_dir(rd_dir), .wr_pucfg(wr_pucfg), .flag_clr(flag_clr),
    .pin_in(pin_in), .rd_data(rd_data), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .irq_flag(irq_flag), .wake_req(wake_req)
  );

  always #10 clk = ~clk;

  // monitor: pops the expectations and compares at the falling edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t e;
      logic [7:0] act;
      e = sb.pop_front();
      case (e.sel)
        0: act = rd_data;
        1: act = pad_out;
        2: act = pad_oe;
        3: act = pad_pu;
        4: act = {7'd0, irq_flag};
        default: act = {7'd0, wake_req};
      endcase
      checks++;
      if (act !== e.exp) begin
        fails++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", e.tag, e.sel, act, e.exp);
      end
    end
  end

  task automatic expect_v(input int sel, input logic [7:0] v, input string tag);
    exp_t e;
    e.sel = sel; e.exp = v; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    wr_port = 0; rd_port = 0; wr_dir = 0; rd_dir = 0; wr_pucfg = 0; flag_clr = 0;
  endtask

  task automatic strobe_write(input int which, input logic [7:0] d);
    wr_data = d;
    if (which == 0) wr_port = 1;
    else if (which == 1) wr_dir = 1;
    else wr_pucfg = 1;
    cyc(); idle();
  endtask

  initial begin
    #1;
    expect_v(2, 8'h00, "R4 pad_oe reset");
    expect_v(3, 8'h00, "R4 pad_pu reset");
    expect_v(1, 8'h00, "R4 pad_out reset");
    expect_v(4, 8'h00, "R4 irq reset");
    repeat (3) cyc();
    rst_n = 1; cyc();
    expect_v(5, 8'h00, "R4 wake idle");
    expect_v(0, 8'h00, "R5 rd_data idle");
    cyc();

    // R1 direction
    rd_dir = 1; expect_v(0, 8'hFF, "R4 dir reset readback"); cyc(); idle();
    strobe_write(1, 8'h0F);
    expect_v(2, 8'hF0, "R1 pad_oe after dir write");
    rd_dir = 1; expect_v(0, 8'h0F, "R1 dir readback"); cyc(); idle();

    // R2 output latch
    strobe_write(0, 8'hA5);
    expect_v(1, 8'hA5, "R2 pad_out"); cyc();

    // R3 pull-ups
    expect_v(3, 8'h00, "R3 pull-ups off while control=1"); cyc();
    strobe_write(2, 8'h00);
    expect_v(3, 8'h0F, "R3 pull-ups on inputs only"); cyc();

    // R5 port read returns pins on all bits
    pin_in = 8'h3C;
    rd_port = 1; expect_v(0, 8'h3C, "R5 port read all bits"); cyc(); idle();

    // R6 upper pins are outputs: no compare
    pin_in = 8'hFC; #1;
    expect_v(5, 8'h00, "R6 output pins excluded wake"); cyc();
    expect_v(4, 8'h00, "R6 output pins excluded flag"); cyc();
    pin_in = 8'h3C;
    strobe_write(1, 8'hFF);
    pin_in = 8'h3D; #1;
    expect_v(5, 8'h00, "R6 lower bits excluded wake"); cyc();
    expect_v(4, 8'h00, "R6 lower bits excluded flag"); cyc();

    // R6/R9 real change on bit 6
    pin_in = 8'h7C; #1;
    expect_v(5, 8'h01, "R9 wake on mismatch"); cyc();
    expect_v(4, 8'h01, "R6 flag set"); cyc();

    // R8 clear loses to a live mismatch
    flag_clr = 1; cyc(); idle();
    expect_v(4, 8'h01, "R8 set wins over clear"); cyc();

    // R7 read resyncs; flag stays sticky
    rd_port = 1; cyc(); idle();
    expect_v(5, 8'h00, "R7 read ends mismatch");
    expect_v(4, 8'h01, "R8 flag sticky after read"); cyc();
    flag_clr = 1; cyc(); idle();
    expect_v(4, 8'h00, "R8 clear after resync"); cyc();

    // R7 write also resyncs
    pin_in = 8'h3C; #1;
    expect_v(5, 8'h01, "R9 wake on second change"); cyc();
    strobe_write(0, 8'h11);
    expect_v(5, 8'h00, "R7 write ends mismatch");
    expect_v(1, 8'h11, "R2 pad_out second write"); cyc();
    flag_clr = 1; cyc(); idle();
    expect_v(4, 8'h00, "R8 clear after write resync"); cyc();

    // R3 pull-up control off again
    strobe_write(2, 8'h01);
    expect_v(3, 8'h00, "R3 pull-ups disabled"); cyc();

    cyc();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule